// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a feedback clock runs at the same frequency as a reference clock. Both clocks arrive as single-cycle edge strobes that have already been synchronized into one fast system clock. One counter counts reference strobes and a second counter counts feedback strobes. When the reference counter finishes a window, the feedback total is compared with the window length. Successive windows alternate between a short length N and a long length N+K, so a feedback clock that is aliased to some other frequency cannot keep passing.

The tolerance depends on lock history. During acquisition only an exact match passes. Three passing compares in a row set the live lock bit, and from then on the tolerance is one count either way. The tolerance widens further while the modulation-active flag is set. Any failing compare drops lock, brings back the exact-match criterion and starts acquisition again from the short window. A sticky bit remembers that lock was reached until a clear request arrives. When the enable is low, the detector stays idle and never reports lock.

Top module: `freq_lock_monitor`

## Requirements
- R1: While enabled, the reference counter advances on every reference strobe and the feedback counter on every feedback strobe, both in the same cycle when both strobes arrive together. The feedback counter saturates at its all-ones value. Both counters return to zero after every compare.
- R2: A compare fires in the cycle of the reference strobe that completes the current window. The feedback total checked in that cycle includes a feedback strobe arriving in the same cycle. After reset the window is N reference strobes. Each passing compare switches the window between N and N+K.
- R3: While unlocked, a compare passes only when the feedback total equals the window length exactly. A failing compare clears the run of passes and returns the window to N.
- R4: The third passing compare in a row while unlocked sets lock_o at the next clock edge.
- R5: While locked with mod_act_i low, a compare passes when the feedback total is within one count of the window length.
- R6: While locked with mod_act_i high, a compare passes when the feedback total is within MOD_TOL counts of the window length.
- R7: A failing compare while locked clears lock_o at the next edge, returns to exact-match tolerance and restarts acquisition from the N window.
- R8: lock_sticky_o sets at the same edge as lock_o rises and stays set after lock_o clears.
- R9: A one-cycle pulse on sticky_clr_i clears lock_sticky_o at the next edge. If lock is reached at that same edge, the set wins and lock_sticky_o stays 1.
- R10: While en_i is low, strobes are ignored, lock_o reads 0 one edge after en_i falls, the sequence returns to the N window with exact-match tolerance, and lock_sticky_o keeps its value.
- R11: A synchronous active-high rst clears both counters, lock_o, lock_sticky_o and the pass run, and selects the N window with exact-match tolerance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock into which both strobes are synchronized |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Detector enable; low means the loop is off |
| ref_stb_i | input | 1 | One-cycle pulse per reference clock edge |
| fb_stb_i | input | 1 | One-cycle pulse per feedback clock edge |
| mod_act_i | input | 1 | Frequency modulation active; widens the loss-of-lock tolerance |
| sticky_clr_i | input | 1 | One-cycle request to clear the sticky lock bit |
| lock_o | output | 1 | Live frequency-lock indication |
| lock_sticky_o | output | 1 | Lock-was-reached indication, held until cleared |

## Verification
The assertions assume that each strobe is a clean one-cycle pulse per clock edge, that mod_act_i stays constant within a compare window, and that a sticky clear request lasts one cycle. They also assume the feedback counter never reaches saturation during a window, which holds as long as the feedback clock is less than about twice the reference rate. The stimulus meets these assumptions. Each window is built as a number of reference strobes equal to the window length. Any feedback strobes beyond that length are placed before the reference strobes, and the rest coincide with the first reference strobes, so every feedback strobe lands at or before the closing reference strobe. The modulation flag changes only between windows, and clear requests are single-cycle pulses.

// File: rtl/flm_pkg.sv
package flm_pkg;

    // Number of consecutive passing compares that declares lock.
    localparam int ACQ_PASSES = 3;
    localparam int PASS_W     = $clog2(ACQ_PASSES);

    // Which of the two alternating window lengths is current.
    typedef enum logic {
        WIN_SHORT = 1'b0,
        WIN_LONG  = 1'b1
    } win_e;

    // Index of each counting channel.
    typedef enum int {
        CH_REF = 0,
        CH_FB  = 1
    } chan_e;

    // Result of one window evaluation.
    typedef struct packed {
        logic hit;  // a compare happens this cycle
        logic ok;   // the feedback total is inside the tolerance
    } cmp_t;

    // Sequencer state.
    typedef struct packed {
        win_e              win;
        logic [PASS_W-1:0] passes;
        logic              locked;
    } seq_st_t;

    localparam seq_st_t SEQ_IDLE = '{win: WIN_SHORT, passes: '0, locked: 1'b0};

    // Counter width that holds twice the longest window without wrapping.
    function automatic int cnt_width(input int n, input int k);
        return $clog2(2 * (n + k) + 2);
    endfunction

    // True when |fb - tgt| <= tol.
    function automatic logic within_tol(input int fb, input int tgt, input int tol);
        int d;
        d = fb - tgt;
        if (d < 0) d = -d;
        return (d <= tol);
    endfunction

endpackage

// File: rtl/flm_strobe_counter.sv
module flm_strobe_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         stb,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (stb && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1: an accepted strobe moves the count up by exactly one
    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        (!clr && stb && (cnt != CNT_MAX)) |=> (cnt == $past(cnt) + 1'b1));

    // R1: a compare leaves the counter at zero
    p_clear_r1: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    // R1: the count never wraps back from its top value
    p_no_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (!clr && (cnt == CNT_MAX)) |=> (cnt == CNT_MAX));

endmodule

// File: rtl/flm_window_compare.sv
module flm_window_compare
    import flm_pkg::*;
#(
    parameter int N       = 32,
    parameter int K       = 8,
    parameter int MOD_TOL = 4,
    parameter int W       = 7
) (
    input  logic         en,
    input  logic         ref_stb,
    input  logic         fb_stb,
    input  logic [W-1:0] ref_cnt,
    input  logic [W-1:0] fb_cnt,
    input  win_e         win,
    input  logic         locked,
    input  logic         mod,
    output cmp_t         cmp
);

    localparam logic [W-1:0] LAST_SHORT = W'(N - 1);
    localparam logic [W-1:0] LAST_LONG  = W'(N + K - 1);

    logic [W-1:0] last_idx;
    int           target;
    int           fb_total;
    int           tol;

    always_comb begin
        last_idx = (win == WIN_LONG) ? LAST_LONG : LAST_SHORT;
        target   = (win == WIN_LONG) ? (N + K) : N;
        fb_total = int'(fb_cnt) + (fb_stb ? 1 : 0);
        if (!locked) begin
            tol = 0;
        end else if (mod) begin
            tol = MOD_TOL;
        end else begin
            tol = 1;
        end
        cmp.hit = en && ref_stb && (ref_cnt == last_idx);
        cmp.ok  = within_tol(fb_total, target, tol);
    end

endmodule

// File: rtl/flm_sequencer.sv
module flm_sequencer
    import flm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  cmp_t cmp,
    output win_e win,
    output logic locked,
    output logic lock_set,
    output logic cnt_clr
);

    seq_st_t st_q;
    seq_st_t st_d;

    localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(ACQ_PASSES - 1);

    always_comb begin
        st_d     = st_q;
        lock_set = 1'b0;
        if (!en) begin
            st_d = SEQ_IDLE;
        end else if (cmp.hit) begin
            if (cmp.ok) begin
                st_d.win = (st_q.win == WIN_LONG) ? WIN_SHORT : WIN_LONG;
                if (!st_q.locked) begin
                    if (st_q.passes == LAST_PASS) begin
                        st_d.locked = 1'b1;
                        st_d.passes = '0;
                        lock_set    = 1'b1;
                    end else begin
                        st_d.passes = st_q.passes + 1'b1;
                    end
                end
            end else begin
                st_d = SEQ_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SEQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign win     = st_q.win;
    assign locked  = st_q.locked;
    assign cnt_clr = cmp.hit || !en;

    // R2: every passing compare switches to the other window length
    p_alternate_r2: assert property (@(posedge clk) disable iff (rst)
        (en && cmp.hit && cmp.ok) |=> (win != $past(win)));

    // R3, R7: a failing compare restarts acquisition from the short window
    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (en && cmp.hit && !cmp.ok) |=> (win == WIN_SHORT && !locked && st_q.passes == '0));

    // R4: lock only rises right after a passing compare
    p_rise_after_pass_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(cmp.hit && cmp.ok));

    // R10: disabling returns the sequence to its idle point
    p_idle_when_off_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!locked && win == WIN_SHORT));

    // R3: the pass run never exceeds its final step
    p_pass_bound_r3: assert property (@(posedge clk) disable iff (rst)
        st_q.passes <= LAST_PASS);

endmodule

// File: rtl/flm_sticky.sv
module flm_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic sticky
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky <= 1'b0;
        end else if (set) begin
            sticky <= 1'b1;
        end else if (clr) begin
            sticky <= 1'b0;
        end
    end

    // R8, R9: a lock event always leaves the bit set, even against a clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        set |=> sticky);

    // R8: without a clear request the bit holds
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (sticky && !clr) |=> sticky);

    // R9: a clear with no coincident lock event empties the bit
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !sticky);

endmodule

// File: rtl/freq_lock_monitor.sv
module freq_lock_monitor
    import flm_pkg::*;
#(
    parameter int N       = 32,
    parameter int K       = 8,
    parameter int MOD_TOL = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic ref_stb_i,
    input  logic fb_stb_i,
    input  logic mod_act_i,
    input  logic sticky_clr_i,
    output logic lock_o,
    output logic lock_sticky_o
);

    localparam int CW     = cnt_width(N, K);
    localparam int N_CHAN = 2;

    logic [N_CHAN-1:0] stb_vec;
    logic [CW-1:0]     cnt_arr [N_CHAN];
    logic              cnt_clr;
    cmp_t              cmp;
    win_e              win;
    logic              locked;
    logic              lock_set;

    assign stb_vec[CH_REF] = ref_stb_i && en_i;
    assign stb_vec[CH_FB]  = fb_stb_i && en_i;

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        flm_strobe_counter #(.W(CW)) u_cnt (
            .clk (clk),
            .rst (rst),
            .clr (cnt_clr),
            .stb (stb_vec[g]),
            .cnt (cnt_arr[g])
        );
    end

    flm_window_compare #(
        .N       (N),
        .K       (K),
        .MOD_TOL (MOD_TOL),
        .W       (CW)
    ) u_cmp (
        .en      (en_i),
        .ref_stb (ref_stb_i),
        .fb_stb  (fb_stb_i),
        .ref_cnt (cnt_arr[CH_REF]),
        .fb_cnt  (cnt_arr[CH_FB]),
        .win     (win),
        .locked  (locked),
        .mod     (mod_act_i),
        .cmp     (cmp)
    );

    flm_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .en       (en_i),
        .cmp      (cmp),
        .win      (win),
        .locked   (locked),
        .lock_set (lock_set),
        .cnt_clr  (cnt_clr)
    );

    flm_sticky u_sticky (
        .clk    (clk),
        .rst    (rst),
        .set    (lock_set),
        .clr    (sticky_clr_i),
        .sticky (lock_sticky_o)
    );

    assign lock_o = locked;

    // R10: no lock is reported once the detector is off
    p_no_lock_off_r10: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !lock_o);

    // R8: a fresh lock is always mirrored in the sticky bit
    p_rise_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_o) |-> lock_sticky_o);

    // R10: while off, the sticky bit can only fall through a clear request
    p_off_keeps_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !sticky_clr_i && lock_sticky_o) |=> lock_sticky_o);

endmodule

// File: tb/test_freq_lock_monitor.sv
module test_freq_lock_monitor;

    localparam int TN   = 8;
    localparam int TK   = 2;
    localparam int TMOD = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_i = 1'b1;
    logic ref_stb_i = 1'b0;
    logic fb_stb_i = 1'b0;
    logic mod_act_i = 1'b0;
    logic sticky_clr_i = 1'b0;
    logic lock_o;
    logic lock_sticky_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit long_win = 1'b0;

    always #10 clk = ~clk;

    freq_lock_monitor #(.N(TN), .K(TK), .MOD_TOL(TMOD)) i_freq_lock_monitor (
        .clk           (clk),
        .rst           (rst),
        .en_i          (en_i),
        .ref_stb_i     (ref_stb_i),
        .fb_stb_i      (fb_stb_i),
        .mod_act_i     (mod_act_i),
        .sticky_clr_i  (sticky_clr_i),
        .lock_o        (lock_o),
        .lock_sticky_o (lock_sticky_o)
    );

    // delta: feedback count minus window length; pass: compare expected to pass
    typedef struct packed {
        int   delta;
        logic mod;
        logic pass;
        logic lock;
        logic sticky;
    } vec_t;

    localparam vec_t VEC [13] = '{
        '{ 0, 1'b0, 1'b1, 1'b0, 1'b0},  // R2 R3 first exact pass, N window
        '{ 0, 1'b0, 1'b1, 1'b0, 1'b0},  // R2 second pass, N+K window
        '{ 0, 1'b0, 1'b1, 1'b1, 1'b1},  // R4 R8 third pass -> lock
        '{ 1, 1'b0, 1'b1, 1'b1, 1'b1},  // R5 +1 tolerated while locked
        '{-1, 1'b0, 1'b1, 1'b1, 1'b1},  // R5 -1 tolerated while locked
        '{ 2, 1'b0, 1'b0, 1'b0, 1'b1},  // R7 R8 +2 drops lock, sticky holds
        '{ 1, 1'b0, 1'b0, 1'b0, 1'b1},  // R3 +1 fails under tight tolerance
        '{ 0, 1'b0, 1'b1, 1'b0, 1'b1},  // R3 reacquire 1
        '{ 0, 1'b0, 1'b1, 1'b0, 1'b1},  // R3 reacquire 2
        '{ 0, 1'b0, 1'b1, 1'b1, 1'b1},  // R4 reacquire 3 -> lock
        '{ 3, 1'b1, 1'b1, 1'b1, 1'b1},  // R6 +3 tolerated with modulation
        '{-3, 1'b1, 1'b1, 1'b1, 1'b1},  // R6 -3 tolerated with modulation
        '{ 4, 1'b1, 1'b0, 1'b0, 1'b1}   // R6 R7 +4 exceeds modulation tolerance
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one window: t reference strobes, f feedback strobes, all feedback
    // strobes at or before the closing reference strobe.
    task automatic run_win(input int t, input int f, input bit mod, input bit clr_last);
        int extra;
        extra = (f > t) ? (f - t) : 0;
        mod_act_i = mod;
        for (int e = 0; e < extra; e++) begin
            @(negedge clk);
            ref_stb_i = 1'b0;
            fb_stb_i  = 1'b1;
        end
        for (int j = 0; j < t; j++) begin
            @(negedge clk);
            ref_stb_i    = 1'b1;
            fb_stb_i     = (j < f);
            sticky_clr_i = clr_last && (j == t - 1);
        end
        @(negedge clk);
        ref_stb_i    = 1'b0;
        fb_stb_i     = 1'b0;
        sticky_clr_i = 1'b0;
    endtask

    function automatic int cur_len();
        return long_win ? (TN + TK) : TN;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset lock", int'(lock_o), 0);
        chk("R11 reset sticky", int'(lock_sticky_o), 0);
        rst = 1'b0;

        // Vector table walk (R2 R3 R4 R5 R6 R7 R8)
        for (int i = 0; i < 13; i++) begin
            run_win(cur_len(), cur_len() + VEC[i].delta, VEC[i].mod, 1'b0);
            chk($sformatf("row %0d lock (R3 R4 R5 R6 R7)", i), int'(lock_o), int'(VEC[i].lock));
            chk($sformatf("row %0d sticky (R8)", i), int'(lock_sticky_o), int'(VEC[i].sticky));
            long_win = VEC[i].pass ? !long_win : 1'b0;
        end
        mod_act_i = 1'b0;

        // R9: a lone clear pulse empties the sticky bit
        @(negedge clk);
        sticky_clr_i = 1'b1;
        @(negedge clk);
        sticky_clr_i = 1'b0;
        chk("R9 clear pulse", int'(lock_sticky_o), 0);

        // R9: clear coinciding with lock acquisition loses to the set
        run_win(cur_len(), cur_len(), 1'b0, 1'b0);
        long_win = !long_win;
        run_win(cur_len(), cur_len(), 1'b0, 1'b0);
        long_win = !long_win;
        run_win(cur_len(), cur_len(), 1'b0, 1'b1);
        long_win = !long_win;
        chk("R9 set priority lock", int'(lock_o), 1);
        chk("R9 set priority sticky", int'(lock_sticky_o), 1);

        // R10: disabling drops lock after one edge, sticky kept
        en_i = 1'b0;
        @(negedge clk);
        chk("R10 lock off", int'(lock_o), 0);
        for (int w = 0; w < 3; w++) begin
            run_win(TN, TN, 1'b0, 1'b0);
        end
        chk("R10 no lock while off", int'(lock_o), 0);
        chk("R10 sticky kept", int'(lock_sticky_o), 1);

        // R1 R10: re-enabled detector restarts from the N window; simultaneous
        // strobes in run_win are all counted so three exact windows lock again
        en_i = 1'b1;
        long_win = 1'b0;
        for (int w = 0; w < 3; w++) begin
            run_win(cur_len(), cur_len(), 1'b0, 1'b0);
            long_win = !long_win;
        end
        chk("R1 R10 relock after enable", int'(lock_o), 1);

        // R11: synchronous reset clears everything
        rst = 1'b1;
        @(negedge clk);
        chk("R11 reset lock", int'(lock_o), 0);
        chk("R11 reset sticky", int'(lock_sticky_o), 0);
        rst = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule